// File: doc/BRIEF.md
# Reservation Table Collision Vector Generator

This block finds the forbidden initiation latencies of a pipeline from its reservation table. The table is a grid of busy marks: one row for each shared resource and one column for each clock cycle that a single initiation spends in the pipeline. Software or a setup sequencer writes the table one row at a time. A start pulse then makes the block slide the table over itself, one candidate latency per cycle, and mark each latency that puts two busy marks of the same row onto the same cycle.

When the scan finishes the block raises `done` and presents the collision vector together with the largest forbidden latency. A scheduler can use these values to choose issue spacings. The table size is set by parameters. The default is 8 resources by 16 cycles, so candidate latencies run from 1 to 15.

Top module: `resv_collision_gen`

## Requirements
- R1: A cycle with `load_row` high writes `row_bits` into table row `row_sel`. Bit j of a row is the mark for cycle j of the initiation, and bit 0 is the earliest cycle.
- R2: Latency k, for k in 1..COLS-1, is forbidden exactly when some single row holds marks at two columns that are k apart. `cvec` bit k-1 is 1 for a forbidden latency k and 0 for a permitted one. Latency 0 has no bit.
- R3: A run of consecutive marks in one row, for a stage that is busy for several cycles, forbids every distance inside the run.
- R4: Marks in the same column of different rows, for resources used in parallel, never collide with each other. Only distances within a single row count.
- R5: `max_lat` equals the largest forbidden latency, and it is 0 when no latency is forbidden.
- R6: A start seen while idle or done begins a scan. `done` rises exactly COLS-1 clock edges after the edge that sampled `start`.
- R7: `done` stays high until the next start. The edge that samples that start clears `done`.
- R8: A start during a scan is ignored: the finish time and the result do not change.
- R9: After reset, `done`, `cvec` and `max_lat` are 0 and every table row is empty.
- R10: For the three-resource table with rows 0xA1, 0x0A and 0x54, `cvec` is 0x005A. Read as C1..C7 this is 0101101: latencies 2, 4, 5 and 7 are forbidden. `max_lat` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_row | input | 1 | Write strobe for one table row |
| row_sel | input | $clog2(ROWS) | Index of the row to write |
| row_bits | input | COLS | Busy marks of the row, bit 0 is the first cycle |
| start | input | 1 | Begins a scan |
| done | output | 1 | Result valid, held until the next start |
| cvec | output | COLS-1 | Collision vector, bit k-1 holds latency k |
| max_lat | output | $clog2(COLS) | Largest forbidden latency, 0 if none |

## Verification
The scan is run on several tables:
- An empty table, which must give an all-zero vector.
- The three-resource reference table, whose marks are spread over several rows.
- A single row with four consecutive marks, which must forbid only the distances inside the run.
- A table with one column shared by several rows, which must forbid nothing until one of those rows gets a second mark 15 cycles later. That case sets the top bit of the vector.

Together these separate a correct within-row comparison from one that mixes rows or skips the longest distance. The timing cases check when `done` arrives, that it holds while no start is given, and that a second start inside a scan changes neither the finish time nor the result.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_t;
endpackage

// File: rtl/rcg_table_store.sv
module rcg_table_store #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [RW-1:0]              wr_row,
  input  logic [COLS-1:0]            wr_bits,
  output logic [ROWS-1:0][COLS-1:0]  table_o
);
  logic [ROWS-1:0][COLS-1:0] tbl_q, tbl_d;

  always_comb begin
    tbl_d = tbl_q;
    if (wr_en) tbl_d[wr_row] = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else if (wr_en) tbl_q <= tbl_d;
  end

  assign table_o = tbl_q;

  // R1: a written row holds the presented marks on the next cycle
  assert_row_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl_q[$past(wr_row)] == $past(wr_bits));
endmodule

// File: rtl/rcg_overlap_eval.sv
module rcg_overlap_eval #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  localparam int LW = $clog2(COLS)
) (
  input  logic [ROWS-1:0][COLS-1:0] table_i,
  input  logic [LW-1:0]             lat,
  output logic                      hit
);
  logic [ROWS-1:0] row_hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_hit[r] = |(table_i[r] & (table_i[r] >> lat));
  end

  assign hit = |row_hit;
endmodule

// File: rtl/rcg_scan_ctrl.sv
module rcg_scan_ctrl #(
  parameter int COLS = 16,
  localparam int LW = $clog2(COLS),
  localparam int NLAT = COLS - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            hit,
  output logic [LW-1:0]   lat,
  output logic            busy,
  output logic            done,
  output logic [NLAT-1:0] cvec
);
  import rcg_pkg::*;

  localparam logic [LW-1:0] LAST = LW'(NLAT);

  scan_state_t     st_q, st_d;
  logic [LW-1:0]   lat_q, lat_d;
  logic [NLAT-1:0] cv_q, cv_d;
  logic            done_q, done_d;

  always_comb begin
    st_d   = st_q;
    lat_d  = lat_q;
    cv_d   = cv_q;
    done_d = done_q;
    case (st_q)
      ST_SCAN: begin
        cv_d[lat_q - 1'b1] = hit;
        if (lat_q == LAST) begin
          st_d   = ST_DONE;
          done_d = 1'b1;
        end else begin
          lat_d = lat_q + 1'b1;
        end
      end
      default: begin
        if (start) begin
          st_d   = ST_SCAN;
          lat_d  = LW'(1);
          cv_d   = '0;
          done_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lat_q  <= '0;
      cv_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lat_q  <= lat_d;
      cv_q   <= cv_d;
      done_q <= done_d;
    end
  end

  assign lat  = lat_q;
  assign busy = (st_q == ST_SCAN);
  assign done = done_q;
  assign cvec = cv_q;

  // R2: latency zero is never evaluated
  assert_lat_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_q != '0));
  // R8: a scan advances one latency per cycle whatever start does
  assert_scan_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat_q != LAST) |=> (busy && lat_q == LW'($past(lat_q) + 1'b1)));
  // R6: finishing the last latency raises done
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat_q == LAST) |=> done);
  // R7: done holds without a start
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R7: a start clears done
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && busy));
endmodule

// File: rtl/resv_collision_gen.sv
module resv_collision_gen #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int LW = $clog2(COLS),
  localparam int NLAT = COLS - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_row,
  input  logic [RW-1:0]   row_sel,
  input  logic [COLS-1:0] row_bits,
  input  logic            start,
  output logic            done,
  output logic [NLAT-1:0] cvec,
  output logic [LW-1:0]   max_lat
);
  logic [ROWS-1:0][COLS-1:0] tbl;
  logic [LW-1:0]             lat;
  logic                      hit;
  logic                      busy;

  rcg_table_store #(.ROWS(ROWS), .COLS(COLS)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(load_row), .wr_row(row_sel),
    .wr_bits(row_bits), .table_o(tbl)
  );

  rcg_overlap_eval #(.ROWS(ROWS), .COLS(COLS)) eval_i (
    .table_i(tbl), .lat(lat), .hit(hit)
  );

  rcg_scan_ctrl #(.COLS(COLS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(hit), .lat(lat),
    .busy(busy), .done(done), .cvec(cvec)
  );

  always_comb begin
    max_lat = '0;
    for (int k = 1; k <= NLAT; k++) begin
      if (cvec[k-1]) max_lat = LW'(k);
    end
  end

  // R5: the highest-latency report is zero exactly when nothing is forbidden
  assert_maxlat_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((max_lat == '0) == (cvec == '0)));
  // R6: done never coincides with an active scan
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

// File: tb/resv_collision_gen_tb_top.sv
module resv_collision_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int COLS = 16;
  localparam int RW = 3;
  localparam int LW = 4;
  localparam int NLAT = COLS - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load_row = 1'b0;
  logic [RW-1:0]   row_sel = '0;
  logic [COLS-1:0] row_bits = '0;
  logic            start = 1'b0;
  logic            done;
  logic [NLAT-1:0] cvec;
  logic [LW-1:0]   max_lat;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [NLAT-1:0] cv;
    logic [LW-1:0]   n;
    logic [7:0]      req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_collision_gen #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_row(load_row), .row_sel(row_sel),
    .row_bits(row_bits), .start(start), .done(done), .cvec(cvec),
    .max_lat(max_lat)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int r, input logic [COLS-1:0] bits);
    @(negedge clk);
    load_row = 1'b1; row_sel = RW'(r); row_bits = bits;
    @(negedge clk);
    load_row = 1'b0;
  endtask

  task automatic clear_table();
    for (int r = 0; r < ROWS; r++) load(r, '0);
  endtask

  // pushes the expected result, runs one scan, checks its timing
  task automatic run_scan(input logic [NLAT-1:0] ecv, input logic [LW-1:0] en,
                          input logic [7:0] req, input bit restart);
    exp_t e;
    e.cv = ecv; e.n = en; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);                 // neg1
    start = 1'b0;
    check(done == 1'b0, "R7 start clears done", 32'(done), 0);
    if (restart) begin
      @(negedge clk);
      @(negedge clk);               // neg3
      start = 1'b1;
      @(negedge clk);               // neg4
      start = 1'b0;
      repeat (10) @(negedge clk);   // neg14
    end else begin
      repeat (13) @(negedge clk);   // neg14
    end
    @(negedge clk);                 // neg15
    check(done == 1'b0, restart ? "R8 no early done" : "R6 no early done",
          32'(done), 0);
    @(negedge clk);                 // neg16
    check(done == 1'b1, restart ? "R8 done on time" : "R6 done on time",
          32'(done), 1);
  endtask

  // monitor: compares each finished scan with the scoreboard
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (done && !done_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected done", 32'(done), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cvec == e.cv, $sformatf("R%0d cvec", e.req), 32'(cvec), 32'(e.cv));
        check(max_lat == e.n, $sformatf("R5 max_lat (case R%0d)", e.req),
              32'(max_lat), 32'(e.n));
      end
    end
    done_prev <= done;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 reset done", 32'(done), 0);
    check(cvec == '0, "R9 reset cvec", 32'(cvec), 0);
    check(max_lat == '0, "R9 reset max_lat", 32'(max_lat), 0);
    rst_n = 1'b1;
    // R9: untouched table scans to nothing
    run_scan('0, '0, 8'd9, 1'b0);
    // R10, R1, R2: three-resource reference table
    load(0, 16'h00A1); load(1, 16'h000A); load(2, 16'h0054);
    run_scan(15'h005A, 4'd7, 8'd10, 1'b0);
    // R7: done held while idle
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R7 done held", 32'(done), 1);
    check(cvec == 15'h005A, "R7 result held", 32'(cvec), 32'h5A);
    // R8: second start inside the scan, same table
    run_scan(15'h005A, 4'd7, 8'd8, 1'b1);
    // R3: one row busy four consecutive cycles
    clear_table();
    load(0, 16'h000F);
    run_scan(15'h0007, 4'd3, 8'd3, 1'b0);
    // R4: same column shared by several rows
    clear_table();
    load(0, 16'h0001); load(1, 16'h0001); load(2, 16'h0001);
    run_scan('0, '0, 8'd4, 1'b0);
    // R2, R1: largest latency reached via a row rewrite
    load(2, 16'h8001);
    run_scan(15'h4000, 4'd15, 8'd2, 1'b0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results seen", 32'(exp_q.size()), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule